// File: doc/BRIEF.md
# Supply-Loss Memory Guard

This block protects a battery-backed static memory while its supply collapses and returns. It watches two comparator flags: one says the supply is under the deselect threshold, the other says it is under the lower battery switchover threshold. From these it blocks the host chip-select towards the array, raises a write-protect flag, forces the data outputs to high impedance and drives the select line of the external power switch.

When the supply fails during a host access, the access gets a bounded grace period to finish. Protection starts when the access ends or when the grace period runs out, whichever comes first. The battery select follows the switchover flag on its own, so the battery is released on power-up while writes are still blocked. After the supply is good again, protection holds for a full recovery interval. Reset enters the protected state, so the first access needs one complete recovery interval. The grace and recovery lengths are cycle-count parameters.

Top module: `pwr_guard`

## Requirements
- R1: During reset and right after it, `wr_prot_o`=1, `out_hiz_o`=1, `mem_sel_o`=0 and `bat_sel_o`=1. Access opens only after one full recovery interval (see R8).
- R2: Both comparator inputs pass through a two-stage synchroniser. A change on `vbat_low_i` reaches `bat_sel_o` on the second rising clock edge after it is applied.
- R3: When `vlow_i` rises in normal operation with `access_busy_i`=0, protection is active after the third rising edge.
- R4: When `vlow_i` rises with `access_busy_i`=1, the block enters a grace period. During grace `mem_sel_o` follows `host_sel_i` and `wr_prot_o`=0. Protection starts on the first edge at which `access_busy_i` is 0.
- R5: Grace never lasts longer than GRACE_CYCLES edges. With the access still busy, protection starts GRACE_CYCLES edges after grace begins.
- R6: While protected, `wr_prot_o`=1, `out_hiz_o`=1 and `mem_sel_o`=0 whatever `host_sel_i` does.
- R7: `bat_sel_o`=1 exactly while the synchronised switchover flag is set. When it clears, the battery is released even if `vlow_i` is still 1 and protection stays on.
- R8: After `vlow_i` and `vbat_low_i` both clear, protection holds. It drops on rising edge 3+RECOVER_CYCLES counted from the clearing.
- R9: If either flag returns during recovery, the block goes back to protected. A later recovery again needs the full RECOVER_CYCLES.
- R10: A set switchover flag forces protection on the next edge, with no grace period, even when an access is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running clock |
| rst_n | input | 1 | active-low asynchronous reset |
| vlow_i | input | 1 | asynchronous flag: supply below deselect threshold |
| vbat_low_i | input | 1 | asynchronous flag: supply below switchover threshold |
| host_sel_i | input | 1 | host chip-select, active high |
| access_busy_i | input | 1 | host access in progress |
| mem_sel_o | output | 1 | gated chip-select to the array |
| wr_prot_o | output | 1 | write protection active |
| out_hiz_o | output | 1 | force data outputs to high impedance |
| bat_sel_o | output | 1 | select battery as array supply |

## Verification
A wrong state shows up almost at once, because every output except the battery select is decoded from the state register. If the block leaves protection too early, `mem_sel_o` follows `host_sel_i` one edge ahead of the point fixed by R8, and the bench samples exactly at that edge. A miscounted grace period moves the rise of `wr_prot_o` by the size of the error. A recovery counter that is not cleared by a dip shortens the second recovery by the cycles already counted. The bench checks both sides of every count boundary.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_GRACE  = 2'd1,
    ST_PROT   = 2'd2,
    ST_RECOV  = 2'd3
  } guard_state_t;

  // bits to count 0 .. max(a,b)-1
  function automatic int cnt_bits(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // edges from a flag change at the pins to a state update
  function automatic int flag_latency(input int stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  // reset to "supply bad" so the block starts safe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
#(
  parameter int GRACE_CYCLES   = 20000,
  parameter int RECOVER_CYCLES = 16000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_s,
  input  logic vbat_s,
  input  logic busy_i,
  output logic protect_o
);

  localparam int CW = cnt_bits(GRACE_CYCLES, RECOVER_CYCLES);
  localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE_CYCLES - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOVER_CYCLES - 1);

  guard_state_t state, nxt;
  logic [CW-1:0] cnt;

  // named events
  logic supply_bad, grace_last, recov_done, grace_exit;
  assign supply_bad = vlow_s | vbat_s;
  assign grace_last = (cnt == GRACE_LAST);
  assign recov_done = (state == ST_RECOV) && !supply_bad && (cnt == RECOV_LAST);
  assign grace_exit = (state == ST_GRACE) && (vbat_s || !busy_i || grace_last);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_NORMAL: begin
        if (vbat_s)      nxt = ST_PROT;
        else if (vlow_s) nxt = busy_i ? ST_GRACE : ST_PROT;
      end
      ST_GRACE:  if (grace_exit) nxt = ST_PROT;
      ST_PROT:   if (!supply_bad) nxt = ST_RECOV;
      ST_RECOV: begin
        if (supply_bad)      nxt = ST_PROT;
        else if (recov_done) nxt = ST_NORMAL;
      end
      default:   nxt = ST_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PROT;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)
        cnt <= '0;
      else if (state == ST_GRACE || state == ST_RECOV)
        cnt <= cnt + 1'b1;
    end
  end

  assign protect_o = (state == ST_PROT) || (state == ST_RECOV);

  a_r3_idle_fail_protects: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && vlow_s && !busy_i) |=> (state == ST_PROT));

  a_r5_grace_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRACE) |-> (int'(cnt) < GRACE_CYCLES));

  a_r8_full_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |->
      ($past(state) == ST_RECOV && $past(cnt) == RECOV_LAST));

  a_r9_dip_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV && supply_bad) |=> (state == ST_PROT && cnt == '0));

  a_r10_battery_forces: assert property (@(posedge clk) disable iff (!rst_n)
    vbat_s |=> protect_o);

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int GRACE_CYCLES   = 20000,
  parameter int RECOVER_CYCLES = 16000000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_i,
  input  logic vbat_low_i,
  input  logic host_sel_i,
  input  logic access_busy_i,
  output logic mem_sel_o,
  output logic wr_prot_o,
  output logic out_hiz_o,
  output logic bat_sel_o
);

  localparam int NFLAGS = 2;

  logic [NFLAGS-1:0] flags_s;
  logic vlow_s, vbat_s, protect;

  pwr_guard_sync #(.W(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({vbat_low_i, vlow_i}),
    .q_o   (flags_s)
  );

  assign vlow_s = flags_s[0];
  assign vbat_s = flags_s[1];

  pwr_guard_fsm #(.GRACE_CYCLES(GRACE_CYCLES), .RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .vlow_s    (vlow_s),
    .vbat_s    (vbat_s),
    .busy_i    (access_busy_i),
    .protect_o (protect)
  );

  assign wr_prot_o = protect;
  assign out_hiz_o = protect;
  assign mem_sel_o = host_sel_i & ~protect;
  assign bat_sel_o = vbat_s;

  a_r8_release_needs_good_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_prot_o) |-> (!vlow_s && !vbat_s));

  a_r7_battery_not_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_sel_o && $past(bat_sel_o)) |-> wr_prot_o);

endmodule

// File: tb/pwr_guard_test.sv
`timescale 1ns/1ps
module pwr_guard_test;

  localparam int G = 6;
  localparam int R = 20;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vlow = 1'b0, vbat = 1'b0, host = 1'b0, busy = 1'b0;
  logic mem_sel, wr_prot, out_hiz, bat_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_guard #(.GRACE_CYCLES(G), .RECOVER_CYCLES(R)) uut (
    .clk(clk), .rst_n(rst_n), .vlow_i(vlow), .vbat_low_i(vbat),
    .host_sel_i(host), .access_busy_i(busy),
    .mem_sel_o(mem_sel), .wr_prot_o(wr_prot), .out_hiz_o(out_hiz), .bat_sel_o(bat_sel)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_normal();
    vlow = 0; vbat = 0; busy = 0; host = 1;
    step(LAT + R);
    check("R8 back to normal", wr_prot, 1'b0);
  endtask

  task automatic t_reset();
    host = 1;
    step(2);
    check("R1 prot in reset", wr_prot, 1'b1);
    check("R1 hiz in reset", out_hiz, 1'b1);
    check("R1 sel blocked in reset", mem_sel, 1'b0);
    check("R1 battery in reset", bat_sel, 1'b1);
    rst_n = 1;
    step(LAT + R - 1);
    check("R8 still protected one edge early", wr_prot, 1'b1);
    check("R1 sel still blocked", mem_sel, 1'b0);
    step(1);
    check("R8 released", wr_prot, 1'b0);
    check("R1 first access passes", mem_sel, 1'b1);
    check("R7 battery off", bat_sel, 1'b0);
  endtask

  task automatic t_idle_fail();
    busy = 0; vlow = 1;
    step(LAT - 1);
    check("R3 not yet protected", wr_prot, 1'b0);
    step(1);
    check("R3 protected", wr_prot, 1'b1);
    check("R6 hiz", out_hiz, 1'b1);
    for (int i = 0; i < 4; i++) begin
      host = i[0];
      #1;
      check("R6 host ignored", mem_sel, 1'b0);
      step(1);
    end
    go_normal();
  endtask

  task automatic t_grace_end();
    busy = 1; host = 1; vlow = 1;
    step(LAT);
    check("R4 grace sel passes", mem_sel, 1'b1);
    check("R4 grace no prot", wr_prot, 1'b0);
    host = 0; #1;
    check("R4 sel follows host", mem_sel, 1'b0);
    host = 1;
    step(2);
    check("R4 grace held", wr_prot, 1'b0);
    busy = 0;
    step(1);
    check("R4 access end protects", wr_prot, 1'b1);
    go_normal();
  endtask

  task automatic t_grace_timeout();
    busy = 1; vlow = 1;
    step(LAT);
    step(G - 1);
    check("R5 last grace edge", wr_prot, 1'b0);
    step(1);
    check("R5 grace expired", wr_prot, 1'b1);
    go_normal();
  endtask

  task automatic t_battery();
    busy = 1; vlow = 1; vbat = 1;
    step(1);
    check("R2 battery not yet", bat_sel, 1'b0);
    step(1);
    check("R2 battery after two edges", bat_sel, 1'b1);
    step(1);
    check("R10 no grace under battery", wr_prot, 1'b1);
    vbat = 0;
    step(2);
    check("R7 battery released", bat_sel, 1'b0);
    check("R7 protection kept", wr_prot, 1'b1);
    step(R + 5);
    check("R7 still protected with vlow", wr_prot, 1'b1);
    go_normal();
  endtask

  task automatic t_dip();
    vlow = 1;
    step(LAT);
    check("R9 protected", wr_prot, 1'b1);
    vlow = 0;
    step(LAT + 5);
    vlow = 1;
    step(LAT);
    vlow = 0;
    step(LAT + R - 1);
    check("R9 restart holds full period", wr_prot, 1'b1);
    step(1);
    check("R9 released after full period", wr_prot, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_fail();
    t_grace_end();
    t_grace_timeout();
    t_battery();
    t_dip();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule